// File: doc/BRIEF.md
# Xon/Xoff Flow Control Status Tracker

This block keeps the software flow control status of one serial channel and presents it as a packed 8-bit word that the host can read. Neighbouring logic reports events to it as single-cycle pulses:
- the receiver reports a matched Xon or Xoff character;
- the transmitter reports an automatic Xon or Xoff it has sent, the end of each character, halt and resume commands, requests to insert a flow character, bit-time ticks and the state of its FIFO;
- the host raises a read strobe in the cycle it samples the word.

The word holds four 2-bit fields. Each field follows its own rule for holding and clearing:
- Bits 7:6 record which flow characters have been received since the last read.
- Bits 5:4 record the last automatic flow character sent. The auto-receiver enable masks this field.
- Bits 3:2 track whether the transmitter is running, about to halt, halted or just restarted.
- Bits 1:0 tell what kind of character the transmitter is currently handling.

Serial shifting, character matching, FIFOs and interrupt logic lie outside the block.

Top module: `swfc_status_tracker`

## Requirements
- R1: While rst_n is low, and after reset is released, the whole status word is 8'h00.
- R2: Bits 7:6 are received-character status. A received Xoff pulse sets bit 6 (code 01) and a received Xon pulse sets bit 7 (code 10). Both accumulate to 11, and the bits hold through idle cycles until a host read.
- R3: A host read clears bits 7:6 at the next edge. If a received event arrives in the same cycle as the read, the field ends up holding exactly that event's bit, so no character is lost.
- R4: Bits 7:6 update on received characters whether the auto-receiver enable is high or low.
- R5: Bits 5:4 are automatic-transmission status. With auto_rx_en high, an auto Xon sent gives 01 and an auto Xoff sent gives 10. The latest event wins, and if both arrive in the same cycle the result is 10. A host read leaves the field unchanged. Code 11 never appears.
- R6: While auto_rx_en is low, bits 5:4 read 00 in that same cycle. Auto-sent events are ignored while the enable is low, and the stored value is cleared, so after re-enabling the field reads 00 until the next auto-sent event.
- R7: Bits 3:2 are transmitter flow status: 00 normal, 01 halt pending, 11 flow disabled, 10 re-enabled. A halt pulse in 00 gives 01. The end of a character in 01 gives 11. A resume pulse in 01 cancels the halt and gives 00.
- R8: In state 11, only a resume pulse changes the flow field, and it moves it to 10. Halt, end-of-character and host read have no effect there.
- R9: In state 10, a host read returns the flow field to 00. A halt pulse moves it to 01, and the halt wins over a read in the same cycle.
- R10: Bits 1:0 are transmitter character status: 00 normal data, 01 waiting on data, 10 Xoff pending, 11 Xon pending. In 00 or 01, an Xoff request gives 10 and an Xon request gives 11; if both arrive together, the Xoff request wins. In 10 or 11, further requests are ignored.
- R11: The end of a character in 10 or 11 moves the character field to 01. The end of a character in 00 has no effect on it.
- R12: In 01 the character field returns to 00 on the first bit tick while tx_fifo_empty is low. It stays at 01 while the FIFO is empty or no tick occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_xon_hit | input | 1 | Receiver matched an Xon character |
| rx_xoff_hit | input | 1 | Receiver matched an Xoff character |
| auto_rx_en | input | 1 | Auto-receiver flow control enable (level) |
| auto_xon_sent | input | 1 | Transmitter sent an automatic Xon |
| auto_xoff_sent | input | 1 | Transmitter sent an automatic Xoff |
| tx_halt | input | 1 | Command to halt transmission after the current character |
| tx_resume | input | 1 | Command to resume transmission |
| tx_char_done | input | 1 | A transmitted character has completed |
| tx_xon_req | input | 1 | Request to insert an Xon into the transmit stream |
| tx_xoff_req | input | 1 | Request to insert an Xoff into the transmit stream |
| bit_tick | input | 1 | One pulse per transmit bit time |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no data (level) |
| host_rd | input | 1 | Host reads the status word this cycle |
| status | output | 8 | Packed status word {rx, auto, flow, char} |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions. One is a host read together with a new received character. Another is a halt together with a read while the flow field shows re-enabled. A third is an end-of-character together with a bit tick while a flow character is pending. The stimulus table first walks the flow field through halt pending, disabled and re-enabled, then fires the colliding pulses in the exact cycle that state holds. The enable-masked automatic field is checked by dropping the enable in the same cycle as an auto-sent pulse and then checking that the field still reads 00 after re-enabling.

// File: rtl/swfc_pkg.sv
package swfc_pkg;

    localparam int FIELD_W  = 2;
    localparam int N_FIELDS = 4;
    localparam int STATUS_W = FIELD_W * N_FIELDS;

    typedef enum logic [FIELD_W-1:0] {
        FLOW_NORMAL   = 2'b00,
        FLOW_HALT_PND = 2'b01,
        FLOW_REENABLE = 2'b10,
        FLOW_STOPPED  = 2'b11
    } flow_state_e;

    typedef enum logic [FIELD_W-1:0] {
        CHR_DATA      = 2'b00,
        CHR_WAIT      = 2'b01,
        CHR_XOFF_PND  = 2'b10,
        CHR_XON_PND   = 2'b11
    } char_state_e;

    typedef enum logic [FIELD_W-1:0] {
        AUTO_NONE     = 2'b00,
        AUTO_XON      = 2'b01,
        AUTO_XOFF     = 2'b10
    } auto_state_e;

endpackage

// File: rtl/swfc_rx_field.sv
module swfc_rx_field
    import swfc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xon_hit,
    input  logic               xoff_hit,
    input  logic               clr,
    output logic [FIELD_W-1:0] fld
);

    typedef struct packed {
        logic seen_xon;
        logic seen_xoff;
    } rx_seen_t;

    rx_seen_t st_d, st_q;

    // Read clears first, then new hits are merged so they survive the read.
    always_comb begin
        st_d = clr ? '0 : st_q;
        if (xon_hit)  st_d.seen_xon  = 1'b1;
        if (xoff_hit) st_d.seen_xoff = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fld = st_q;

endmodule

// File: rtl/swfc_auto_field.sv
module swfc_auto_field
    import swfc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               xon_sent,
    input  logic               xoff_sent,
    output logic [FIELD_W-1:0] fld
);

    auto_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = AUTO_NONE;
        end else if (xoff_sent) begin
            st_d = AUTO_XOFF;
        end else if (xon_sent) begin
            st_d = AUTO_XON;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= AUTO_NONE;
        else        st_q <= st_d;
    end

    // Masked so the field reads zero in the very cycle the enable drops.
    assign fld = en ? st_q : AUTO_NONE;

endmodule

// File: rtl/swfc_flow_fsm.sv
module swfc_flow_fsm
    import swfc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt,
    input  logic               resume,
    input  logic               char_done,
    input  logic               host_rd,
    output logic [FIELD_W-1:0] fld
);

    flow_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLOW_NORMAL: begin
                if (halt) st_d = FLOW_HALT_PND;
            end
            FLOW_HALT_PND: begin
                if (resume)         st_d = FLOW_NORMAL;
                else if (char_done) st_d = FLOW_STOPPED;
            end
            FLOW_STOPPED: begin
                if (resume) st_d = FLOW_REENABLE;
            end
            FLOW_REENABLE: begin
                if (halt)         st_d = FLOW_HALT_PND;
                else if (host_rd) st_d = FLOW_NORMAL;
            end
            default: st_d = FLOW_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLOW_NORMAL;
        else        st_q <= st_d;
    end

    assign fld = st_q;

endmodule

// File: rtl/swfc_char_fsm.sv
module swfc_char_fsm
    import swfc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xon_req,
    input  logic               xoff_req,
    input  logic               char_done,
    input  logic               bit_tick,
    input  logic               fifo_empty,
    output logic [FIELD_W-1:0] fld
);

    char_state_e st_d, st_q;
    logic        can_queue;

    always_comb begin
        st_d      = st_q;
        can_queue = (st_q == CHR_DATA) || (st_q == CHR_WAIT);
        if (can_queue && xoff_req) begin
            st_d = CHR_XOFF_PND;
        end else if (can_queue && xon_req) begin
            st_d = CHR_XON_PND;
        end else begin
            unique case (st_q)
                CHR_XOFF_PND, CHR_XON_PND: begin
                    if (char_done) st_d = CHR_WAIT;
                end
                CHR_WAIT: begin
                    if (bit_tick && !fifo_empty) st_d = CHR_DATA;
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CHR_DATA;
        else        st_q <= st_d;
    end

    assign fld = st_q;

endmodule

// File: rtl/swfc_status_tracker.sv
module swfc_status_tracker
    import swfc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_xon_hit,
    input  logic                rx_xoff_hit,
    input  logic                auto_rx_en,
    input  logic                auto_xon_sent,
    input  logic                auto_xoff_sent,
    input  logic                tx_halt,
    input  logic                tx_resume,
    input  logic                tx_char_done,
    input  logic                tx_xon_req,
    input  logic                tx_xoff_req,
    input  logic                bit_tick,
    input  logic                tx_fifo_empty,
    input  logic                host_rd,
    output logic [STATUS_W-1:0] status
);

    logic [FIELD_W-1:0] rx_fld;
    logic [FIELD_W-1:0] auto_fld;
    logic [FIELD_W-1:0] flow_fld;
    logic [FIELD_W-1:0] char_fld;

    swfc_rx_field u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .xon_hit  (rx_xon_hit),
        .xoff_hit (rx_xoff_hit),
        .clr      (host_rd),
        .fld      (rx_fld)
    );

    swfc_auto_field u_auto (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (auto_rx_en),
        .xon_sent  (auto_xon_sent),
        .xoff_sent (auto_xoff_sent),
        .fld       (auto_fld)
    );

    swfc_flow_fsm u_flow (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt      (tx_halt),
        .resume    (tx_resume),
        .char_done (tx_char_done),
        .host_rd   (host_rd),
        .fld       (flow_fld)
    );

    swfc_char_fsm u_char (
        .clk        (clk),
        .rst_n      (rst_n),
        .xon_req    (tx_xon_req),
        .xoff_req   (tx_xoff_req),
        .char_done  (tx_char_done),
        .bit_tick   (bit_tick),
        .fifo_empty (tx_fifo_empty),
        .fld        (char_fld)
    );

    // Field order is fixed: software decodes these bit positions.
    assign status = {rx_fld, auto_fld, flow_fld, char_fld};

endmodule

// File: rtl/swfc_status_chk.sv
module swfc_status_chk
    import swfc_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                rx_xon_hit,
    input logic                rx_xoff_hit,
    input logic                auto_rx_en,
    input logic                tx_resume,
    input logic                tx_xon_req,
    input logic                tx_xoff_req,
    input logic                tx_fifo_empty,
    input logic                host_rd,
    input logic [STATUS_W-1:0] status
);

    assert_rx_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> ((status[7:6] & $past(status[7:6])) == $past(status[7:6])));

    assert_rd_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !rx_xon_hit && !rx_xoff_hit) |=> (status[7:6] == 2'b00));

    assert_auto_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        status[5:4] != 2'b11);

    assert_auto_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_rx_en |-> (status[5:4] == 2'b00));

    assert_stopped_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3:2] == 2'b11 && !tx_resume) |=> (status[3:2] == 2'b11));

    assert_stopped_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3:2] == 2'b11 && tx_resume) |=> (status[3:2] == 2'b10));

    assert_wait_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1:0] == 2'b01 && tx_fifo_empty && !tx_xon_req && !tx_xoff_req)
        |=> (status[1:0] == 2'b01));

endmodule

bind swfc_status_tracker swfc_status_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_xon_hit    (rx_xon_hit),
    .rx_xoff_hit   (rx_xoff_hit),
    .auto_rx_en    (auto_rx_en),
    .tx_resume     (tx_resume),
    .tx_xon_req    (tx_xon_req),
    .tx_xoff_req   (tx_xoff_req),
    .tx_fifo_empty (tx_fifo_empty),
    .host_rd       (host_rd),
    .status        (status)
);

// File: tb/swfc_status_tracker_tb.sv
module swfc_status_tracker_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_xon_hit = 0, rx_xoff_hit = 0, auto_rx_en = 0;
    logic       auto_xon_sent = 0, auto_xoff_sent = 0;
    logic       tx_halt = 0, tx_resume = 0, tx_char_done = 0;
    logic       tx_xon_req = 0, tx_xoff_req = 0, bit_tick = 0;
    logic       tx_fifo_empty = 0, host_rd = 0;
    logic [7:0] status;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    swfc_status_tracker dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_xon_hit     (rx_xon_hit),
        .rx_xoff_hit    (rx_xoff_hit),
        .auto_rx_en     (auto_rx_en),
        .auto_xon_sent  (auto_xon_sent),
        .auto_xoff_sent (auto_xoff_sent),
        .tx_halt        (tx_halt),
        .tx_resume      (tx_resume),
        .tx_char_done   (tx_char_done),
        .tx_xon_req     (tx_xon_req),
        .tx_xoff_req    (tx_xoff_req),
        .bit_tick       (bit_tick),
        .tx_fifo_empty  (tx_fifo_empty),
        .host_rd        (host_rd),
        .status         (status)
    );

    // Input bits (MSB first): rx_xon rx_xoff | auto_en | auto_xon auto_xoff |
    // halt resume | char_done | xon_req xoff_req | tick | fifo_empty | rd
    localparam int NV = 31;
    localparam logic [20:0] VEC [NV] = '{
        {13'b01_1_00_00_0_00_0_0_0, 8'b01_00_00_00},
        {13'b10_0_00_00_0_00_0_0_0, 8'b11_00_00_00},
        {13'b00_1_00_00_0_00_0_0_1, 8'b00_00_00_00},
        {13'b00_1_10_00_0_00_0_0_0, 8'b00_01_00_00},
        {13'b01_1_00_00_0_00_0_0_1, 8'b01_01_00_00},
        {13'b00_1_11_00_0_00_0_0_0, 8'b01_10_00_00},
        {13'b00_0_10_00_0_00_0_0_0, 8'b01_00_00_00},
        {13'b00_1_00_00_0_00_0_0_0, 8'b01_00_00_00},
        {13'b00_1_00_10_0_00_0_0_0, 8'b01_00_01_00},
        {13'b00_1_00_00_1_00_0_0_0, 8'b01_00_11_00},
        {13'b00_1_00_10_1_00_0_0_1, 8'b00_00_11_00},
        {13'b00_1_00_01_0_00_0_0_0, 8'b00_00_10_00},
        {13'b00_1_00_10_0_00_0_0_1, 8'b00_00_01_00},
        {13'b00_1_00_01_0_00_0_0_0, 8'b00_00_00_00},
        {13'b00_1_00_10_0_00_0_0_0, 8'b00_00_01_00},
        {13'b00_1_00_00_1_00_0_0_0, 8'b00_00_11_00},
        {13'b00_1_00_01_0_00_0_0_0, 8'b00_00_10_00},
        {13'b00_1_00_00_0_00_0_0_1, 8'b00_00_00_00},
        {13'b00_1_00_00_0_11_0_0_0, 8'b00_00_00_10},
        {13'b00_1_00_00_0_10_0_0_0, 8'b00_00_00_10},
        {13'b00_1_00_00_1_00_0_0_0, 8'b00_00_00_01},
        {13'b00_1_00_00_0_00_1_1_0, 8'b00_00_00_01},
        {13'b00_1_00_00_0_00_0_0_0, 8'b00_00_00_01},
        {13'b00_1_00_00_0_00_1_0_0, 8'b00_00_00_00},
        {13'b00_1_00_00_0_10_0_0_0, 8'b00_00_00_11},
        {13'b00_1_00_00_1_00_0_0_0, 8'b00_00_00_01},
        {13'b00_1_00_00_0_01_0_0_0, 8'b00_00_00_10},
        {13'b00_1_00_00_1_00_0_0_0, 8'b00_00_00_01},
        {13'b00_1_00_00_0_10_1_0_0, 8'b00_00_00_11},
        {13'b00_1_00_00_1_00_1_0_0, 8'b00_00_00_01},
        {13'b00_1_00_00_0_00_1_0_0, 8'b00_00_00_00}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1:     return "R2/R4 received accumulate";
            2, 4:     return "R3 read clear, event wins";
            3, 5:     return "R5 auto sent, read keeps";
            6, 7:     return "R6 auto masked and cleared";
            8, 9:     return "R7 halt then stop";
            10, 11:   return "R8 stopped holds, resume";
            12:       return "R9 halt beats read";
            13:       return "R7 resume cancels halt";
            14, 15:   return "R7 halt path again";
            16, 17:   return "R9 read returns normal";
            18, 19:   return "R10 request priority";
            20, 25:   return "R11 char done to wait";
            21, 22:   return "R12 wait holds";
            23:       return "R12 wait exits on tick";
            24, 26:   return "R10 request from data/wait";
            27, 29:   return "R11 char done to wait";
            28:       return "R10 request beats tick";
            default:  return "R12 wait exits on tick";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] exp);
        n_tests++;
        if (status !== exp) begin
            n_fail++;
            $display("FAIL %s: status=%b expected=%b", tag, status, exp);
        end
    endtask

    task automatic drive(input logic [12:0] v);
        rx_xon_hit     = v[12];
        rx_xoff_hit    = v[11];
        auto_rx_en     = v[10];
        auto_xon_sent  = v[9];
        auto_xoff_sent = v[8];
        tx_halt        = v[7];
        tx_resume      = v[6];
        tx_char_done   = v[5];
        tx_xon_req     = v[4];
        tx_xoff_req    = v[3];
        bit_tick       = v[2];
        tx_fifo_empty  = v[1];
        host_rd        = v[0];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        drive(13'b0);
        repeat (3) @(negedge clk);
        check("R1 held in reset", 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 8'h00);

        // Table walk: drive at a falling edge, sample at the next one.
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][20:8]);
            @(negedge clk);
            check(vec_tag(i), VEC[i][7:0]);
        end

        // R2: both hits in one cycle give 11 and hold through idle cycles.
        drive(13'b11_1_00_00_0_00_0_0_0);
        @(negedge clk);
        drive(13'b00_1_00_00_0_00_0_0_0);
        repeat (3) @(negedge clk);
        check("R2 both held idle", 8'b11_00_00_00);

        // R3: read with Xon arriving keeps only Xon.
        drive(13'b10_1_00_00_0_00_0_0_1);
        @(negedge clk);
        check("R3 read with xon", 8'b10_00_00_00);

        // R6: enable drop is seen in the same cycle, before any edge.
        drive(13'b00_1_01_00_0_00_0_0_0);
        @(negedge clk);
        check("R5 auto xoff", 8'b10_10_00_00);
        drive(13'b00_0_00_00_0_00_0_0_0);
        #1;
        check("R6 same-cycle mask", 8'b10_00_00_00);
        @(negedge clk);

        // R11: char done while in data does nothing.
        drive(13'b00_1_00_00_1_00_0_0_0);
        @(negedge clk);
        check("R11 done in data ignored", 8'b10_00_00_00);

        // R1: asynchronous reset in mid-run clears everything.
        drive(13'b01_1_10_10_0_10_0_0_0);
        @(negedge clk);
        drive(13'b00_1_00_00_0_00_0_0_0);
        rst_n = 1'b0;
        #1;
        check("R1 mid-run reset", 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after second release", 8'h00);

        finish_run();
    end

endmodule